// File: doc/BRIEF.md
# PCI Function Power-State Controller

This block follows the power-management state of one network function on a PCI-style bus and gates the function's bus behaviour to suit that state. Software selects a full-power state or one of three reduced-power states through a field in configuration space. The full-power state has two substates. The function starts uninitialized and becomes active once a base-address register has been given a non-zero value.

While the function sits in a reduced-power state, only configuration-space accesses are accepted. Bus mastering and interrupts are held off. A wake-packet match or a link-status change sets a sticky wake status. When the wake enable is set, that status drives the active-low power-management event output low until software clears it. A link-status change also counts as a wake event in the active full-power substate. Reset is asynchronous when asserted and is released through a small synchronizer.

Top module: `pcipm_state_ctrl`

## Requirements
- R1: After reset, the reported state is 0 (full-power, uninitialized), the wake status is 0, the event output is high, and no base-address register counts as programmed.
- R2: In the uninitialized substate (0), a base-address write with non-zero data moves the state to 1 (full-power, active) on the next cycle. A write with zero data leaves the state at 0.
- R3: A power-state write takes effect on the next cycle. Request codes 1, 2 and 3 give states 2, 3 and 4. Request code 0 gives state 1 when the current state is 1 or any base-address register is programmed after this cycle's writes, and gives state 0 otherwise. When a power-state write and a base-address write arrive in the same cycle, the power-state write decides the state.
- R4: A power-state write with a request code of 4 to 7 is ignored and leaves the state unchanged.
- R5: The access-accept output is high whenever a configuration access is strobed. A memory or I/O access is accepted only in states 0 and 1.
- R6: The bus-master and interrupt enables are high only in state 1.
- R7: A wake packet or a link change in states 2, 3 or 4 sets the wake status on the next cycle. A link change in state 1 also sets it. A wake packet in states 0 or 1, or a link change in state 0, does not set it.
- R8: The event output is low exactly when the wake status is set and the wake enable is high. The wake status holds until a clear strobe, and a set in the same cycle as a clear wins.
- R9: Base-address writes are taken in every state. Each register's programmed flag follows whether its last written value was non-zero, so a reduced-power function whose registers were all zeroed returns to state 0 when code 0 is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Function clock |
| rst_n | input | 1 | Asynchronous active-low bus reset |
| ps_wr_en | input | 1 | Strobe for a power-state field write |
| ps_wr_val | input | 3 | Requested state code (0..3 valid, 4..7 reserved) |
| bar_wr_en | input | 3 | One strobe per base-address register (control/status, memory, I/O) |
| bar_wr_nonzero | input | 1 | The data of the current base-address write is non-zero |
| cfg_acc | input | 1 | Configuration-space access strobe |
| mem_acc | input | 1 | Memory or I/O access strobe |
| wake_pkt | input | 1 | Wake-packet match pulse |
| link_chg | input | 1 | Link-status-change pulse |
| pme_en | input | 1 | Wake enable bit |
| pme_sts_clr | input | 1 | Write-one-to-clear strobe for the wake status |
| pwr_state | output | 3 | Current state: 0 uninit, 1 active, 2/3/4 reduced |
| bm_en | output | 1 | Bus-master enable |
| irq_en | output | 1 | Interrupt enable |
| acc_ok | output | 1 | Current access is accepted |
| pme_sts | output | 1 | Sticky wake status |
| pme_n | output | 1 | Active-low power-management event |

## Verification
Directed sequences drive the following cases:
- zero and non-zero base-address writes in the uninitialized substate, which separates the value-sensitive transition from a plain strobe;
- reserved request codes in a reduced-power state;
- a return to full power after all base registers were cleared, which tells the two full-power substates apart on wake-up;
- a wake packet with the enable set and then cleared, which separates the status bit from the output pin.

A long stretch of random strobes then mixes state requests, register writes, wake pulses and clears in the same cycles. This exercises the priorities: a state write over a register write, and a set over a clear. A behavioural model is compared against every output on every cycle.

// File: rtl/pcipm_pkg.sv
package pcipm_pkg;
  localparam int PS_W    = 3;
  localparam int REQ_W   = 3;
  localparam int NUM_BAR = 3;

  typedef enum logic [PS_W-1:0] {
    PS_D0U = 3'd0,
    PS_D0A = 3'd1,
    PS_D1  = 3'd2,
    PS_D2  = 3'd3,
    PS_D3  = 3'd4
  } pwr_state_e;

  localparam logic [REQ_W-1:0] REQ_D0 = 3'd0;
  localparam logic [REQ_W-1:0] REQ_D1 = 3'd1;
  localparam logic [REQ_W-1:0] REQ_D2 = 3'd2;
  localparam logic [REQ_W-1:0] REQ_D3 = 3'd3;

  function automatic logic is_low_power(input pwr_state_e s);
    return (s == PS_D1) || (s == PS_D2) || (s == PS_D3);
  endfunction
endpackage

// File: rtl/pcipm_rst_sync.sv
module pcipm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pcipm_state_fsm.sv
module pcipm_state_fsm
  import pcipm_pkg::*;
#(
  parameter int N_BAR = NUM_BAR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ps_wr_en,
  input  logic [REQ_W-1:0]  ps_wr_val,
  input  logic [N_BAR-1:0]  bar_wr_en,
  input  logic              bar_wr_nonzero,
  output pwr_state_e        state_o
);
  localparam int REQ_MAX = 3;

  pwr_state_e       state_q, state_d;
  logic [N_BAR-1:0] prog_q, prog_d;
  logic             prog_en;
  logic             req_valid;
  logic             any_prog_d;

  // per-register programmed flag, last written value decides
  for (genvar i = 0; i < N_BAR; i++) begin : g_bar
    always_comb begin
      prog_d[i] = prog_q[i];
      if (bar_wr_en[i]) prog_d[i] = bar_wr_nonzero;
    end
  end

  assign prog_en    = |bar_wr_en;
  assign any_prog_d = |prog_d;
  assign req_valid  = ps_wr_en && (int'(ps_wr_val) <= REQ_MAX);

  always_comb begin
    state_d = state_q;
    if (req_valid) begin
      unique case (ps_wr_val)
        REQ_D0:  state_d = ((state_q == PS_D0A) || any_prog_d) ? PS_D0A : PS_D0U;
        REQ_D1:  state_d = PS_D1;
        REQ_D2:  state_d = PS_D2;
        REQ_D3:  state_d = PS_D3;
        default: state_d = state_q;
      endcase
    end else if ((state_q == PS_D0U) && any_prog_d) begin
      state_d = PS_D0A;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prog_q <= '0;
    else if (prog_en) prog_q <= prog_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_D0U;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/pcipm_wake_ctrl.sv
module pcipm_wake_ctrl
  import pcipm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e state,
  input  logic       wake_pkt,
  input  logic       link_chg,
  input  logic       pme_en,
  input  logic       pme_sts_clr,
  output logic       pme_sts,
  output logic       pme_n
);
  logic sts_q, sts_d, sts_en, wake_set;

  assign wake_set = (is_low_power(state) && (wake_pkt || link_chg))
                 || ((state == PS_D0A) && link_chg);
  assign sts_en   = wake_set || pme_sts_clr;

  always_comb begin
    sts_d = sts_q;
    if (pme_sts_clr) sts_d = 1'b0;
    if (wake_set)    sts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= 1'b0;
    else if (sts_en) sts_q <= sts_d;
  end

  assign pme_sts = sts_q;
  assign pme_n   = ~(sts_q & pme_en);
endmodule

// File: rtl/pcipm_bus_gate.sv
module pcipm_bus_gate
  import pcipm_pkg::*;
(
  input  pwr_state_e state,
  input  logic       cfg_acc,
  input  logic       mem_acc,
  output logic       acc_ok,
  output logic       bm_en,
  output logic       irq_en
);
  logic in_d0, active;

  assign in_d0  = (state == PS_D0U) || (state == PS_D0A);
  assign active = (state == PS_D0A);
  assign acc_ok = cfg_acc || (mem_acc && in_d0);
  assign bm_en  = active;
  assign irq_en = active;
endmodule

// File: rtl/pcipm_state_ctrl.sv
module pcipm_state_ctrl
  import pcipm_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ps_wr_en,
  input  logic [REQ_W-1:0]   ps_wr_val,
  input  logic [NUM_BAR-1:0] bar_wr_en,
  input  logic               bar_wr_nonzero,
  input  logic               cfg_acc,
  input  logic               mem_acc,
  input  logic               wake_pkt,
  input  logic               link_chg,
  input  logic               pme_en,
  input  logic               pme_sts_clr,
  output logic [PS_W-1:0]    pwr_state,
  output logic               bm_en,
  output logic               irq_en,
  output logic               acc_ok,
  output logic               pme_sts,
  output logic               pme_n
);
  logic       rst_sync_n;
  pwr_state_e cur_state;

  pcipm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  pcipm_state_fsm #(.N_BAR(NUM_BAR)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .ps_wr_en       (ps_wr_en),
    .ps_wr_val      (ps_wr_val),
    .bar_wr_en      (bar_wr_en),
    .bar_wr_nonzero (bar_wr_nonzero),
    .state_o        (cur_state)
  );

  pcipm_wake_ctrl u_wake (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .state       (cur_state),
    .wake_pkt    (wake_pkt),
    .link_chg    (link_chg),
    .pme_en      (pme_en),
    .pme_sts_clr (pme_sts_clr),
    .pme_sts     (pme_sts),
    .pme_n       (pme_n)
  );

  pcipm_bus_gate u_gate (
    .state   (cur_state),
    .cfg_acc (cfg_acc),
    .mem_acc (mem_acc),
    .acc_ok  (acc_ok),
    .bm_en   (bm_en),
    .irq_en  (irq_en)
  );

  assign pwr_state = cur_state;
endmodule

// File: rtl/pcipm_sva.sv
module pcipm_sva
  import pcipm_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               ps_wr_en,
  input logic [REQ_W-1:0]   ps_wr_val,
  input logic [NUM_BAR-1:0] bar_wr_en,
  input logic               bar_wr_nonzero,
  input logic               cfg_acc,
  input logic               mem_acc,
  input logic               wake_pkt,
  input logic               link_chg,
  input logic               pme_en,
  input logic               pme_sts_clr,
  input logic [PS_W-1:0]    pwr_state,
  input logic               bm_en,
  input logic               irq_en,
  input logic               acc_ok,
  input logic               pme_sts,
  input logic               pme_n
);
  logic low_pwr;
  assign low_pwr = (pwr_state >= 3'd2) && (pwr_state <= 3'd4);

  assert_init_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd0 && (|bar_wr_en) && bar_wr_nonzero && !ps_wr_en) |=> pwr_state == 3'd1)
    else $error("R2 violated");

  assert_req_d3_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_wr_en && ps_wr_val == 3'd3) |=> pwr_state == 3'd4)
    else $error("R3 violated");

  assert_reserved_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_wr_en && ps_wr_val[2] && pwr_state != 3'd0) |=> $stable(pwr_state))
    else $error("R4 violated");

  assert_mem_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (low_pwr && mem_acc && !cfg_acc) |-> !acc_ok)
    else $error("R5 violated");

  assert_master_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 3'd1) |-> (!bm_en && !irq_en))
    else $error("R6 violated");

  assert_wake_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (low_pwr && (wake_pkt || link_chg)) |=> pme_sts)
    else $error("R7 violated");

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_sts && !pme_sts_clr) |=> pme_sts)
    else $error("R8 violated");

  assert_pin_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pme_en |-> pme_n)
    else $error("R8 gate violated");
endmodule

bind pcipm_state_ctrl pcipm_sva u_sva (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .ps_wr_en       (ps_wr_en),
  .ps_wr_val      (ps_wr_val),
  .bar_wr_en      (bar_wr_en),
  .bar_wr_nonzero (bar_wr_nonzero),
  .cfg_acc        (cfg_acc),
  .mem_acc        (mem_acc),
  .wake_pkt       (wake_pkt),
  .link_chg       (link_chg),
  .pme_en         (pme_en),
  .pme_sts_clr    (pme_sts_clr),
  .pwr_state      (pwr_state),
  .bm_en          (bm_en),
  .irq_en         (irq_en),
  .acc_ok         (acc_ok),
  .pme_sts        (pme_sts),
  .pme_n          (pme_n)
);

// File: tb/pcipm_state_ctrl_tb_top.sv
module pcipm_state_ctrl_tb_top;
  logic       clk;
  logic       rst_n;
  logic       ps_wr_en;
  logic [2:0] ps_wr_val;
  logic [2:0] bar_wr_en;
  logic       bar_wr_nonzero;
  logic       cfg_acc, mem_acc, wake_pkt, link_chg, pme_en, pme_sts_clr;
  logic [2:0] pwr_state;
  logic       bm_en, irq_en, acc_ok, pme_sts, pme_n;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  run      = 0;
  bit  done     = 0;

  // behavioural reference
  int  m_st   = 0;
  bit  [2:0] m_bar = 3'b000;
  bit  m_sts  = 0;

  pcipm_state_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ps_wr_en(ps_wr_en), .ps_wr_val(ps_wr_val),
    .bar_wr_en(bar_wr_en), .bar_wr_nonzero(bar_wr_nonzero), .cfg_acc(cfg_acc),
    .mem_acc(mem_acc), .wake_pkt(wake_pkt), .link_chg(link_chg), .pme_en(pme_en),
    .pme_sts_clr(pme_sts_clr), .pwr_state(pwr_state), .bm_en(bm_en),
    .irq_en(irq_en), .acc_ok(acc_ok), .pme_sts(pme_sts), .pme_n(pme_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (run) begin
      bit [2:0] nb;
      bit wset;
      nb = m_bar;
      for (int i = 0; i < 3; i++) if (bar_wr_en[i]) nb[i] = bar_wr_nonzero;
      wset = ((m_st >= 2) && (wake_pkt || link_chg)) || ((m_st == 1) && link_chg);
      m_sts = wset || (m_sts && !pme_sts_clr);
      if (ps_wr_en && ps_wr_val < 3'd4) begin
        case (ps_wr_val)
          3'd0:    m_st = (m_st == 1 || nb != 0) ? 1 : 0;
          3'd1:    m_st = 2;
          3'd2:    m_st = 3;
          default: m_st = 4;
        endcase
      end else if (m_st == 0 && nb != 0) begin
        m_st = 1;
      end
      m_bar = nb;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 state", int'(pwr_state), m_st);
    chk("R7 wake status", int'(pme_sts), int'(m_sts));
    chk("R8 event pin", int'(pme_n), int'(!(m_sts && pme_en)));
    chk("R6 bus master", int'(bm_en), int'(m_st == 1));
    chk("R6 interrupt", int'(irq_en), int'(m_st == 1));
    chk("R5 access", int'(acc_ok), int'(cfg_acc || (mem_acc && m_st <= 1)));
  endtask

  task automatic clear_pulses();
    ps_wr_en = 0; ps_wr_val = 0; bar_wr_en = 0; bar_wr_nonzero = 0;
    cfg_acc = 0; mem_acc = 0; wake_pkt = 0; link_chg = 0; pme_sts_clr = 0;
  endtask

  // compare, advance one clock, land on the next falling edge with idle pulses
  task automatic step();
    #1 compare_all();
    @(negedge clk);
    clear_pulses();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; pme_en = 0;
    clear_pulses();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    #1;
    chk("R1 state", int'(pwr_state), 0);
    chk("R1 status", int'(pme_sts), 0);
    chk("R1 pin", int'(pme_n), 1);
    run = 1;
    @(negedge clk);

    // R2 zero write keeps uninitialized, non-zero write activates
    bar_wr_en = 3'b010; bar_wr_nonzero = 0; step();
    chk("R2 zero write", int'(pwr_state), 0);
    bar_wr_en = 3'b100; bar_wr_nonzero = 1; step();
    chk("R2 nonzero write", int'(pwr_state), 1);

    // R7 wake packet in active substate ignored
    wake_pkt = 1; step();
    chk("R7 pkt in active", int'(pme_sts), 0);

    // R3 enter D3, R4 reserved codes ignored
    ps_wr_en = 1; ps_wr_val = 3'd3; step();
    chk("R3 to D3", int'(pwr_state), 4);
    for (int c = 4; c < 8; c++) begin
      ps_wr_en = 1; ps_wr_val = 3'(c); step();
      chk("R4 reserved", int'(pwr_state), 4);
    end

    // R5 memory refused, config accepted in D3
    mem_acc = 1; #1 chk("R5 mem in D3", int'(acc_ok), 0);
    cfg_acc = 1; #1 chk("R5 cfg in D3", int'(acc_ok), 1);
    step();

    // R7/R8 wake packet with enable, clear, set-wins
    pme_en = 1; wake_pkt = 1; step();
    chk("R7 pkt in D3", int'(pme_sts), 1);
    chk("R8 pin low", int'(pme_n), 0);
    pme_en = 0; #1 chk("R8 gated", int'(pme_n), 1);
    pme_en = 1;
    link_chg = 1; pme_sts_clr = 1; step();
    chk("R8 set wins", int'(pme_sts), 1);
    pme_sts_clr = 1; step();
    chk("R8 cleared", int'(pme_sts), 0);
    chk("R8 pin released", int'(pme_n), 1);

    // R9 zero the remaining register in D3, return to D0 uninitialized
    bar_wr_en = 3'b100; bar_wr_nonzero = 0; step();
    ps_wr_en = 1; ps_wr_val = 3'd0; step();
    chk("R9 back to uninit", int'(pwr_state), 0);
    // R9 program in D1 then return to active
    ps_wr_en = 1; ps_wr_val = 3'd1; step();
    bar_wr_en = 3'b001; bar_wr_nonzero = 1; step();
    chk("R9 stays D1", int'(pwr_state), 2);
    ps_wr_en = 1; ps_wr_val = 3'd0; step();
    chk("R9 back to active", int'(pwr_state), 1);

    // mixed random traffic, model compared every cycle
    for (int n = 0; n < 4000; n++) begin
      ps_wr_en       = ($urandom % 8) == 0;
      ps_wr_val      = 3'($urandom % 8);
      for (int b = 0; b < 3; b++) bar_wr_en[b] = ($urandom % 12) == 0;
      bar_wr_nonzero = ($urandom % 3) != 0;
      cfg_acc        = ($urandom % 4) == 0;
      mem_acc        = ($urandom % 2) == 0;
      wake_pkt       = ($urandom % 10) == 0;
      link_chg       = ($urandom % 12) == 0;
      pme_sts_clr    = ($urandom % 7) == 0;
      if (($urandom % 20) == 0) pme_en = ~pme_en;
      step();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule